// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a programmable watchdog for a system-on-chip. Firmware programs two timeout codes and a response mode, sets the enable bit, and must then keep proving that it is alive. It does so by writing one fixed key value to a service register before a down-counter runs out. Each timeout code `c` selects a period of `2^(BASE_EXP+c)` clock cycles. With the default `BASE_EXP` of 16, the periods run from 2^16 to 2^31 cycles on a 32-bit counter. The first period after enabling uses its own code, so the first service can come later than the ones after it.

When the counter runs out, the block either requests a system reset at once or, in the warning mode, raises an interrupt first and gives firmware one more normal period. The reset request is a fixed-length pulse. After the pulse the watchdog disables itself, and firmware must arm it again.

Access is through a simple single-cycle register port. A write takes effect on the clock edge where `we_i` is high. Reads are combinational from `addr_i`.

Top module: `wdt_keyed`

## Requirements
- R1: On an asynchronous reset (`rst_ni` low), every register clears to zero at once, and `irq_o` and `rst_req_o` are low. This holds even while the watchdog is counting.
- R2: Offset 0x00 is the control register: bit 0 is enable, bit 1 is mode (1 = warning first). Offset 0x04 holds the normal code in bits [3:0] and the first-period code in bits [7:4]. Both registers read back these bits, and all other bits read as zero.
- R3: The service register at 0x0C reads as zero. Every unmapped offset (for example 0x08 or 0x10) also reads as zero.
- R4: A control write that sets bit 0 while the watchdog is disabled loads the counter with the first-period length. In mode 0, `rst_req_o` then rises exactly `2^(BASE_EXP+first code)` cycles after that write edge.
- R5: While the watchdog is enabled, writing exactly 0x76 to 0x0C reloads the normal period. The next expiry comes `2^(BASE_EXP+normal code)` cycles after that write edge.
- R6: A write to 0x0C of any value other than 0x76 changes nothing. The pending expiry keeps its original time.
- R7: A write of 0x76 to 0x0C while the watchdog is disabled has no effect; a pending interrupt stays set.
- R8: Writing 0 to enable stops the counter. No expiry and no reset request follow while the watchdog is disabled.
- R9: In mode 0, an expiry raises `rst_req_o` directly, and `irq_o` stays low.
- R10: In mode 1, the first expiry raises `irq_o` and reloads the normal period. A second expiry with no valid service in between raises `rst_req_o`.
- R11: A valid service write clears `irq_o` on the next edge and restarts the normal period.
- R12: `rst_req_o` stays high for exactly `RST_LEN` (8) cycles. When it falls, the enable bit reads back as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W (8) | Register byte offset |
| wdata_i | input | DATA_W (32) | Write data |
| we_i | input | 1 | Write strobe, sampled on the rising clock edge |
| rdata_o | output | DATA_W (32) | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Warning interrupt (mode 1) |
| rst_req_o | output | 1 | System reset request pulse |

## Verification
The checker assumes the bus presents one address per cycle, so a service write and a control write never fall on the same edge. The check on the order of interrupt and reset takes the mode from the cycle of the expiry, so it assumes firmware does not change the mode in the edge where the counter expires. The bench drives every input on the falling edge, issues one write at a time, and keeps the mode fixed for the length of each run. It overrides `BASE_EXP` to 4, which gives periods of 16, 32 and 64 cycles.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned OFF_CTRL = 32'h00;
  localparam int unsigned OFF_TORR = 32'h04;
  localparam int unsigned OFF_SERV = 32'h0C;
  localparam int unsigned SERV_KEY = 32'h76;

  typedef struct packed {
    logic mode;
    logic en;
  } ctrl_t;

  typedef enum logic [1:0] {
    RS_RUN    = 2'd0,
    RS_WARNED = 2'd1,
    RS_RESET  = 2'd2
  } resp_state_e;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              clr_en_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              en_o,
  output logic              mode_o,
  output logic [CODE_W-1:0] norm_code_o,
  output logic [CODE_W-1:0] init_code_o,
  output logic              start_o,
  output logic              kick_o
);
  localparam int TORR_W = 2 * CODE_W;

  ctrl_t             ctrl_q;
  logic [TORR_W-1:0] torr_q;
  logic              sel_ctrl, sel_torr, sel_serv;

  assign sel_ctrl = (addr_i == ADDR_W'(OFF_CTRL));
  assign sel_torr = (addr_i == ADDR_W'(OFF_TORR));
  assign sel_serv = (addr_i == ADDR_W'(OFF_SERV));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      torr_q <= '0;
    end else begin
      if (we_i && sel_ctrl) begin
        ctrl_q.en   <= wdata_i[0];
        ctrl_q.mode <= wdata_i[1];
      end
      // end of a reset pulse wins over a same-cycle write
      if (clr_en_i) ctrl_q.en <= 1'b0;
      if (we_i && sel_torr) torr_q <= wdata_i[TORR_W-1:0];
    end
  end

  assign start_o = we_i && sel_ctrl && wdata_i[0] && !ctrl_q.en;
  assign kick_o  = we_i && sel_serv && (wdata_i == DATA_W'(SERV_KEY)) && ctrl_q.en;

  always_comb begin
    rdata_o = '0;
    if (sel_ctrl)      rdata_o[1:0]        = {ctrl_q.mode, ctrl_q.en};
    else if (sel_torr) rdata_o[TORR_W-1:0] = torr_q;
  end

  assign en_o        = ctrl_q.en;
  assign mode_o      = ctrl_q.mode;
  assign norm_code_o = torr_q[CODE_W-1:0];
  assign init_code_o = torr_q[TORR_W-1:CODE_W];
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W    = 32,
  parameter int CODE_W   = 4,
  parameter int BASE_EXP = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              hold_i,
  input  logic              start_i,
  input  logic              kick_i,
  input  logic [CODE_W-1:0] init_code_i,
  input  logic [CODE_W-1:0] norm_code_i,
  output logic              expire_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam int NUM_CODES = 1 << CODE_W;

  logic [CNT_W-1:0] reload_lut [NUM_CODES];
  logic [CNT_W-1:0] cnt_q;
  logic             run;

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_lut
    assign reload_lut[g] = (CNT_W'(1) << (BASE_EXP + g)) - CNT_W'(1);
  end

  assign run      = en_i && !hold_i;
  assign expire_o = run && !kick_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= reload_lut[init_code_i];
    end else if (run) begin
      if (kick_i || cnt_q == '0) cnt_q <= reload_lut[norm_code_i];
      else                       cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdt_resp.sv
module wdt_resp
  import wdt_pkg::*;
#(
  parameter int RST_LEN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic kick_i,
  input  logic start_i,
  input  logic mode_i,
  output logic irq_o,
  output logic rst_req_o,
  output logic clr_en_o
);
  localparam int LEN_W = $clog2(RST_LEN + 1);
  localparam logic [LEN_W-1:0] LAST = LEN_W'(RST_LEN - 1);

  resp_state_e      state_q, state_d;
  logic [LEN_W-1:0] len_q, len_d;

  always_comb begin
    state_d = state_q;
    len_d   = len_q;
    unique case (state_q)
      RS_RUN: begin
        if (expire_i) begin
          if (mode_i) begin
            state_d = RS_WARNED;
          end else begin
            state_d = RS_RESET;
            len_d   = '0;
          end
        end
      end
      RS_WARNED: begin
        if (expire_i) begin
          state_d = RS_RESET;
          len_d   = '0;
        end else if (kick_i || start_i) begin
          state_d = RS_RUN;
        end
      end
      RS_RESET: begin
        if (len_q == LAST) state_d = RS_RUN;
        else               len_d   = len_q + LEN_W'(1);
      end
      default: state_d = RS_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RS_RUN;
      len_q   <= '0;
    end else begin
      state_q <= state_d;
      len_q   <= len_d;
    end
  end

  assign irq_o     = (state_q == RS_WARNED);
  assign rst_req_o = (state_q == RS_RESET);
  assign clr_en_o  = (state_q == RS_RESET) && (len_q == LAST);
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 32,
  parameter int CODE_W   = 4,
  parameter int BASE_EXP = 16,
  parameter int RST_LEN  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic              en, mode, start, kick, expire, clr_en;
  logic [CODE_W-1:0] norm_code, init_code;
  logic [CNT_W-1:0]  cnt;

  wdt_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .we_i       (we_i),
    .clr_en_i   (clr_en),
    .rdata_o    (rdata_o),
    .en_o       (en),
    .mode_o     (mode),
    .norm_code_o(norm_code),
    .init_code_o(init_code),
    .start_o    (start),
    .kick_o     (kick)
  );

  wdt_counter #(
    .CNT_W(CNT_W), .CODE_W(CODE_W), .BASE_EXP(BASE_EXP)
  ) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .hold_i     (rst_req_o),
    .start_i    (start),
    .kick_i     (kick),
    .init_code_i(init_code),
    .norm_code_i(norm_code),
    .expire_o   (expire),
    .cnt_o      (cnt)
  );

  wdt_resp #(
    .RST_LEN(RST_LEN)
  ) u_resp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .expire_i (expire),
    .kick_i   (kick),
    .start_i  (start),
    .mode_i   (mode),
    .irq_o    (irq_o),
    .rst_req_o(rst_req_o),
    .clr_en_o (clr_en)
  );
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk
  import wdt_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 32,
  parameter int RST_LEN = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              we_i,
  input logic              irq_o,
  input logic              rst_req_o,
  input logic              en_i,
  input logic              mode_i,
  input logic              start_i,
  input logic [CNT_W-1:0]  cnt_i
);
  localparam int HW = $clog2(RST_LEN + 2);

  logic [HW-1:0] hi_cnt;
  logic          serv_wr, good_key;

  assign serv_wr  = we_i && (addr_i == ADDR_W'(OFF_SERV));
  assign good_key = (wdata_i == DATA_W'(SERV_KEY));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hi_cnt <= '0;
    else if (rst_req_o) hi_cnt <= hi_cnt + HW'(1);
    else                hi_cnt <= '0;
  end

  p_bad_key_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serv_wr && !good_key && en_i && !rst_req_o && cnt_i != '0 |=> cnt_i == $past(cnt_i) - CNT_W'(1));

  p_frozen_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !start_i |=> $stable(cnt_i));

  p_quiet_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !rst_req_o |=> !rst_req_o);

  p_warn_first_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) && $past(mode_i) |-> $past(irq_o));

  p_serv_clears_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serv_wr && good_key && en_i |=> !irq_o);

  p_pulse_cap_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> hi_cnt < HW'(RST_LEN));

  p_pulse_len_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_req_o) |-> hi_cnt == HW'(RST_LEN));

  p_end_off_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_req_o) |-> !en_i);
endmodule

bind wdt_keyed wdt_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .RST_LEN(RST_LEN)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .we_i     (we_i),
  .irq_o    (irq_o),
  .rst_req_o(rst_req_o),
  .en_i     (en),
  .mode_i   (mode),
  .start_i  (start),
  .cnt_i    (cnt)
);

// File: tb/sim_wdt_keyed.sv
`timescale 1ns/1ps
module sim_wdt_keyed;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int BE = 4;
  localparam int NV = 8;
  // entry: {addr[8], wdata[32], we[1], expected read[32]}
  localparam logic [72:0] VECS [NV] = '{
    {8'h04, 32'h0000_00A5, 1'b1, 32'h0000_00A5},
    {8'h04, 32'hFFFF_FF3C, 1'b1, 32'h0000_003C},
    {8'h00, 32'hFFFF_FFFE, 1'b1, 32'h0000_0002},
    {8'h00, 32'h0000_0000, 1'b1, 32'h0000_0000},
    {8'h0C, 32'h0000_0076, 1'b1, 32'h0000_0000},
    {8'h08, 32'hFFFF_FFFF, 1'b1, 32'h0000_0000},
    {8'h10, 32'h0000_0000, 1'b0, 32'h0000_0000},
    {8'h04, 32'h0000_0000, 1'b1, 32'h0000_0000}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          we = 1'b0;
  logic [DW-1:0] rdata;
  logic          irq, rst_req;
  int            tests = 0, fails = 0;
  bit            done = 1'b0;

  always #10 clk = ~clk;

  wdt_keyed #(.BASE_EXP(BE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .irq_o(irq), .rst_req_o(rst_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    addr = a; we = 1'b0;
    #1 chk(tag, rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  // which: 0 = reset request, 1 = interrupt; n = edges until it is high
  task automatic wait_hi(input bit which, output int n);
    n = 0;
    while (((which ? irq : rst_req) == 1'b0) && n < 4000) begin
      @(posedge clk); @(negedge clk); n++;
    end
  endtask

  task automatic wait_pulse_end(output int n);
    n = 0;
    while (rst_req && n < 100) begin @(posedge clk); @(negedge clk); n++; end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n, m;
    @(negedge clk); @(negedge clk);
    // R1 reset state
    rd(8'h00, 32'h0, "R1 ctrl");
    rd(8'h04, 32'h0, "R1 torr");
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 rst_req", {31'b0, rst_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R3 register table
    for (int i = 0; i < NV; i++) begin
      logic [72:0] v;
      v = VECS[i];
      if (v[32]) wr(v[72:65], v[64:33]);
      rd(v[72:65], v[31:0], (v[72:65] == 8'h00 || v[72:65] == 8'h04) ? "R2 readback" : "R3 zero read");
    end

    // R4 R9 R12: first period 32, normal 16, mode 0
    wr(8'h04, 32'h10);
    wr(8'h00, 32'h1);
    wait_hi(1'b0, n);
    chk("R4 first period", n, 32);
    chk("R9 no irq", {31'b0, irq}, 32'h0);
    wait_pulse_end(n);
    chk("R12 pulse length", n, 8);
    rd(8'h00, 32'h0, "R12 enable cleared");

    // R6: wrong key leaves expiry time unchanged
    wr(8'h04, 32'h11);
    wr(8'h00, 32'h1);
    idle(10);
    wr(8'h0C, 32'h77);
    wait_hi(1'b0, m);
    chk("R6 wrong key", 11 + m, 32);
    wait_pulse_end(n);

    // R5: good key restarts the normal period
    wr(8'h00, 32'h1);
    idle(20);
    wr(8'h0C, 32'h76);
    wait_hi(1'b0, m);
    chk("R5 restart", m, 32);
    wait_pulse_end(n);

    // R10: warning then reset, first 32 then normal 16
    wr(8'h04, 32'h10);
    wr(8'h00, 32'h3);
    wait_hi(1'b1, n);
    chk("R10 irq time", n, 32);
    chk("R10 no reset yet", {31'b0, rst_req}, 32'h0);
    wait_hi(1'b0, m);
    chk("R10 second expiry", m, 16);
    wait_pulse_end(n);

    // R11: service clears interrupt and reloads
    wr(8'h00, 32'h3);
    wait_hi(1'b1, n);
    wr(8'h0C, 32'h76);
    chk("R11 irq cleared", {31'b0, irq}, 32'h0);
    wait_hi(1'b1, m);
    chk("R11 reload", m, 16);
    chk("R11 no reset", {31'b0, rst_req}, 32'h0);

    // R7 / R8: disable, then service while off
    wr(8'h00, 32'h2);
    wr(8'h0C, 32'h76);
    chk("R7 irq kept", {31'b0, irq}, 32'h1);
    idle(200);
    chk("R8 no reset while off", {31'b0, rst_req}, 32'h0);
    chk("R8 irq still", {31'b0, irq}, 32'h1);
    rd(8'h00, 32'h2, "R8 ctrl off");

    // R1: asynchronous reset mid-count
    wr(8'h04, 32'h22);
    wr(8'h00, 32'h1);
    idle(5);
    #3 rst_n = 1'b0;
    rd(8'h00, 32'h0, "R1 async ctrl");
    rd(8'h04, 32'h0, "R1 async torr");
    chk("R1 async irq", {31'b0, irq}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(100);
    chk("R1 stays idle", {31'b0, rst_req}, 32'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule